// File: doc/BRIEF.md
# Multiplexed Bus Transfer Sequencer

This block runs one processor bus transfer at a time over a shared 16-bit address/data path. A requester presents an address, a two-bit space code, a write flag and write data with a one-tick start pulse. The sequencer then drives the address with a strobe, latches it on the strobe's falling edge, and enters a request phase. In that phase an active-low request line is low, write data is driven or the path is released for input, and a ready input is polled at fixed points. When ready is found high, read data is captured and a one-tick done pulse returns it to the requester.

During the request phase the space code and the write flag are decoded into eight separate active-low command strobes: locked memory, plain memory, peripheral I/O and external register, each as a read and a write. A direct-memory-access enable takes away the output enables of the latched address and of the command strobes, so another master can drive them. The transfer carries on unchanged underneath.

Timing runs on a fast clock at twice the processor bus rate. One processor clock is two ticks, so the half-period sampling point of ready falls on a tick edge.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, busy and done are 0, addr_strobe is 0, req_n is 1, all eight cmd_n bits are 1, ad_oe and buf_oe are 0, rd_data is 0, and with dma_en low both lat_oe and cmd_oe are 1.
- R2: A start accepted while idle makes addr_strobe high for exactly 2 ticks, starting on the next edge. During those ticks ad_oe is 1 and ad_out carries the address. busy is 1 from that edge until the transfer ends.
- R3: lat_addr takes the address one tick after addr_strobe falls and keeps it until the next transfer's strobe falls.
- R4: req_n goes low on the edge where addr_strobe falls. During the request phase, a write has ad_oe=1 and ad_out equal to the write data, and a read has ad_oe=0.
- R5: rdy is first sampled on the third edge after req_n falls. A high rdy before that edge does not end the transfer.
- R6: Each time rdy is sampled low, the transfer waits 2 more ticks and samples rdy again, with req_n still low.
- R7: On the edge where rdy is sampled high, req_n returns to 1, busy to 0 and done pulses high for one tick. A read loads rd_data with ad_in; a write leaves rd_data unchanged.
- R8: During the request phase exactly one cmd_n bit is low: bit index = 2*space + wr, with space 00 locked memory, 01 memory, 10 peripheral I/O, 11 external register and wr=1 for a write. Outside the request phase all bits are 1.
- R9: buf_oe is 1 only while req_n is 0, and during the request phase buf_dir equals the write flag.
- R10: While dma_en is 1, lat_oe and cmd_oe are 0 in the same cycle. The sequencing, its timing and the data outputs are unaffected.
- R11: A start raised while busy is ignored: the running transfer keeps its address and no second transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| start_addr | input | 16 | Transfer address |
| start_space | input | 2 | Address space code |
| start_wr | input | 1 | 1 = write, 0 = read |
| start_wdata | input | 16 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-tick completion pulse |
| rd_data | output | 16 | Data captured by the last read |
| ad_out | output | 16 | Shared path, driven value |
| ad_oe | output | 1 | Shared path drive enable |
| ad_in | input | 16 | Shared path, received value |
| addr_strobe | output | 1 | Address strobe, high in address phase |
| req_n | output | 1 | Active-low transfer request |
| rdy | input | 1 | Device ready |
| lat_addr | output | 16 | Demultiplexed latched address |
| lat_oe | output | 1 | Latched address output enable |
| cmd_n | output | 8 | Active-low command strobes |
| cmd_oe | output | 1 | Command strobe output enable |
| buf_dir | output | 1 | Data buffer direction, 1 toward the bus |
| buf_oe | output | 1 | Data buffer enable |
| dma_en | input | 1 | DMA master owns the bus |

## Verification
The hardest case to reach is the ready input being high at an edge where it must not be sampled, or low at a sampling edge followed by later retries. A wrong count in the phase counter still completes the transfer, only on the wrong tick. The stimulus therefore holds rdy high from the first request tick in the no-wait vectors, and raises it only just before the final sampling edge in vectors with one to three waits. It then demands that done and req_n stay quiet on every tick before that edge. Starts while busy and a DMA takeover during a live transfer are driven as directed cases, and their effects are checked at the latch, strobe and enable outputs.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ADDR = 2'b01,
    ST_REQ  = 2'b10
  } bcs_state_e;

  typedef enum logic [1:0] {
    SP_MEM_LOCK = 2'b00,
    SP_MEM      = 2'b01,
    SP_IO       = 2'b10,
    SP_XREG     = 2'b11
  } bcs_space_e;

  localparam int SPACE_W = 2;
  localparam int NUM_CMD = 2 ** (SPACE_W + 1);
endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
#(
  parameter int W           = 16,
  parameter int ADDR_TICKS  = 2,
  parameter int FIRST_TICKS = 3,
  parameter int RETRY_TICKS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [W-1:0]       start_addr,
  input  logic [SPACE_W-1:0] start_space,
  input  logic               start_wr,
  input  logic [W-1:0]       start_wdata,
  input  logic               rdy,
  input  logic [W-1:0]       ad_in,
  output logic               busy,
  output logic               done,
  output logic [W-1:0]       rd_data,
  output logic               astrb,
  output logic               req_active,
  output logic [W-1:0]       ad_out,
  output logic               ad_oe,
  output logic [SPACE_W-1:0] space_o,
  output logic               wr_o
);
  localparam int MAXT = (ADDR_TICKS > FIRST_TICKS) ? ADDR_TICKS : FIRST_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] ADDR_LAST  = CW'(ADDR_TICKS - 1);
  localparam logic [CW-1:0] SAMPLE_AT  = CW'(FIRST_TICKS - 1);
  localparam logic [CW-1:0] RETRY_FROM = CW'(FIRST_TICKS - RETRY_TICKS);

  bcs_state_e         st_q, st_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [W-1:0]       addr_q, wdata_q, rdata_q;
  logic [SPACE_W-1:0] space_q;
  logic               wr_q, done_q;
  logic               load, finish;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    load   = 1'b0;
    finish = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_ADDR;
          cnt_d = '0;
          load  = 1'b1;
        end
      end
      ST_ADDR: begin
        if (cnt_q == ADDR_LAST) begin
          st_d  = ST_REQ;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_REQ: begin
        if (cnt_q == SAMPLE_AT) begin
          if (rdy) begin
            st_d   = ST_IDLE;
            cnt_d  = '0;
            finish = 1'b1;
          end else begin
            cnt_d = RETRY_FROM;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      space_q <= '0;
      wr_q    <= 1'b0;
    end else if (load) begin
      addr_q  <= start_addr;
      wdata_q <= start_wdata;
      space_q <= start_space;
      wr_q    <= start_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= finish;
      if (finish && !wr_q) begin
        rdata_q <= ad_in;
      end
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign rd_data    = rdata_q;
  assign astrb      = (st_q == ST_ADDR);
  assign req_active = (st_q == ST_REQ);
  assign ad_out     = (st_q == ST_ADDR) ? addr_q : wdata_q;
  assign ad_oe      = (st_q == ST_ADDR) || ((st_q == ST_REQ) && wr_q);
  assign space_o    = space_q;
  assign wr_o       = wr_q;

  AST_ADDR_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(astrb) |-> $past(astrb, 2)); // R2
  AST_REQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_active) |-> $past(astrb)); // R4
  AST_DONE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!req_active && $past(req_active))); // R7
  AST_BUSY_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(addr_q)); // R11
endmodule

// File: rtl/bcs_addr_latch.sv
module bcs_addr_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] bus,
  output logic [W-1:0] lat_addr
);
  logic         strobe_d;
  logic [W-1:0] bus_d, addr_q;
  logic         trail;

  assign trail = strobe_d && !strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d <= 1'b0;
      bus_d    <= '0;
    end else begin
      strobe_d <= strobe;
      bus_d    <= bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (trail) begin
      addr_q <= bus_d;
    end
  end

  assign lat_addr = addr_q;

  AST_LATCH_ON_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |=> (lat_addr == $past(bus, 2))); // R3
endmodule

// File: rtl/bcs_cmd_decode.sv
module bcs_cmd_decode
  import bcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic [SPACE_W-1:0] space,
  input  logic               wr,
  output logic [NUM_CMD-1:0] cmd_n
);
  logic [SPACE_W:0] sel;
  assign sel = {space, wr};

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    assign cmd_n[g] = !(active && (sel == (SPACE_W + 1)'(g)));
  end

  AST_ONE_CMD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($countones(~cmd_n) == 1)); // R8
  AST_CMD_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> $onehot0(~cmd_n) && (cmd_n[sel] == 1'b1)); // R8
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int W           = 16,
  parameter int ADDR_TICKS  = 2,
  parameter int FIRST_TICKS = 3,
  parameter int RETRY_TICKS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [W-1:0]       start_addr,
  input  logic [SPACE_W-1:0] start_space,
  input  logic               start_wr,
  input  logic [W-1:0]       start_wdata,
  output logic               busy,
  output logic               done,
  output logic [W-1:0]       rd_data,
  output logic [W-1:0]       ad_out,
  output logic               ad_oe,
  input  logic [W-1:0]       ad_in,
  output logic               addr_strobe,
  output logic               req_n,
  input  logic               rdy,
  output logic [W-1:0]       lat_addr,
  output logic               lat_oe,
  output logic [NUM_CMD-1:0] cmd_n,
  output logic               cmd_oe,
  output logic               buf_dir,
  output logic               buf_oe,
  input  logic               dma_en
);
  logic [1:0]         rst_sync_q;
  logic               rst_ni;
  logic               req_active, wr_q;
  logic [SPACE_W-1:0] space_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  bcs_fsm #(
    .W(W), .ADDR_TICKS(ADDR_TICKS), .FIRST_TICKS(FIRST_TICKS), .RETRY_TICKS(RETRY_TICKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_ni),
    .start(start), .start_addr(start_addr), .start_space(start_space),
    .start_wr(start_wr), .start_wdata(start_wdata),
    .rdy(rdy), .ad_in(ad_in),
    .busy(busy), .done(done), .rd_data(rd_data),
    .astrb(addr_strobe), .req_active(req_active),
    .ad_out(ad_out), .ad_oe(ad_oe),
    .space_o(space_q), .wr_o(wr_q)
  );

  bcs_addr_latch #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_ni), .strobe(addr_strobe), .bus(ad_out), .lat_addr(lat_addr)
  );

  bcs_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_ni), .active(req_active), .space(space_q), .wr(wr_q), .cmd_n(cmd_n)
  );

  assign req_n   = !req_active;
  assign buf_oe  = req_active;
  assign buf_dir = wr_q;
  assign lat_oe  = !dma_en;
  assign cmd_oe  = !dma_en;

  AST_BUF_ONLY_IN_REQ: assert property (@(posedge clk) disable iff (!rst_ni)
    buf_oe |-> (!req_n && !addr_strobe)); // R9
  AST_DMA_FLOATS: assert property (@(posedge clk) disable iff (!rst_ni)
    dma_en |-> (!lat_oe && !cmd_oe)); // R10
endmodule

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, start_wr, rdy, dma_en;
  logic [15:0] start_addr, start_wdata, ad_in;
  logic [1:0]  start_space;
  logic        busy, done, ad_oe, addr_strobe, req_n, lat_oe, cmd_oe, buf_dir, buf_oe;
  logic [15:0] rd_data, ad_out, lat_addr;
  logic [7:0]  cmd_n;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] exp_rd = 16'h0000;

  always #2 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_space(start_space), .start_wr(start_wr), .start_wdata(start_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .addr_strobe(addr_strobe), .req_n(req_n), .rdy(rdy),
    .lat_addr(lat_addr), .lat_oe(lat_oe), .cmd_n(cmd_n), .cmd_oe(cmd_oe),
    .buf_dir(buf_dir), .buf_oe(buf_oe), .dma_en(dma_en)
  );

  typedef struct packed {
    logic [1:0]  space;
    logic        wr;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [3:0]  nwait;
    logic [15:0] rdval;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 16'h1000, 16'h0000, 4'd0, 16'hA5A5},
    '{2'b00, 1'b1, 16'h1002, 16'hBEEF, 4'd1, 16'h0000},
    '{2'b01, 1'b0, 16'h8000, 16'h0000, 4'd2, 16'h1234},
    '{2'b01, 1'b1, 16'h8004, 16'hCAFE, 4'd0, 16'h0000},
    '{2'b10, 1'b0, 16'h0030, 16'h0000, 4'd3, 16'h00C3},
    '{2'b10, 1'b1, 16'h0031, 16'h0042, 4'd1, 16'h0000},
    '{2'b11, 1'b0, 16'h00FF, 16'h0000, 4'd0, 16'h003C},
    '{2'b11, 1'b1, 16'h00FE, 16'h0015, 4'd2, 16'h0000}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // One full transfer; inject = raise a stray start while busy, dma = take the bus
  task automatic run_xfer(input vec_t v, input bit inject, input bit dma);
    int total;
    logic [7:0] exp_cmd;
    exp_cmd = ~(8'h01 << {v.space, v.wr});
    total = 3 + 2 * int'(v.nwait);
    start = 1'b1; start_addr = v.addr; start_space = v.space;
    start_wr = v.wr; start_wdata = v.wdata; rdy = 1'b0; ad_in = v.rdval;
    if (dma) dma_en = 1'b1;
    tick();
    chk("R2", "strobe", addr_strobe, 1'b1);
    chk("R2", "ad_out addr", ad_out, v.addr);
    chk("R2", "ad_oe", ad_oe, 1'b1);
    chk("R2", "busy", busy, 1'b1);
    chk("R8", "cmd idle in addr", cmd_n, 8'hFF);
    if (dma) begin
      chk("R10", "lat_oe", lat_oe, 1'b0);
      chk("R10", "cmd_oe", cmd_oe, 1'b0);
    end
    if (inject) begin
      start_addr = 16'h5555; start_space = ~v.space; start_wr = ~v.wr;
    end else begin
      start = 1'b0;
    end
    tick();
    start = 1'b0;
    chk("R2", "strobe 2nd tick", addr_strobe, 1'b1);
    tick();
    chk("R2", "strobe length", addr_strobe, 1'b0);
    chk("R4", "req_n low", req_n, 1'b0);
    chk("R4", "ad_oe in req", ad_oe, v.wr);
    if (v.wr) chk("R4", "write data", ad_out, v.wdata);
    chk("R8", "cmd strobe", cmd_n, exp_cmd);
    chk("R9", "buf_oe", buf_oe, 1'b1);
    chk("R9", "buf_dir", buf_dir, v.wr);
    if (v.nwait == 0) rdy = 1'b1;  // early high ready must be ignored
    for (int i = 1; i <= total; i++) begin
      if (i == total) rdy = 1'b1;
      tick();
      if (i == 1) chk("R3", "lat_addr", lat_addr, v.addr);
      if (i < total) begin
        chk(i < 3 ? "R5" : "R6", "no early done", done, 1'b0);
        chk(i < 3 ? "R5" : "R6", "req held", req_n, 1'b0);
      end
    end
    rdy = 1'b0;
    if (!v.wr) exp_rd = v.rdval;
    chk("R7", "done", done, 1'b1);
    chk("R7", "req_n release", req_n, 1'b1);
    chk("R7", "busy clear", busy, 1'b0);
    chk("R7", "rd_data", rd_data, exp_rd);
    chk("R8", "cmd release", cmd_n, 8'hFF);
    chk("R9", "buf_oe off", buf_oe, 1'b0);
    tick();
    chk("R7", "done one tick", done, 1'b0);
    if (dma) begin
      chk("R10", "lat_oe still off", lat_oe, 1'b0);
      dma_en = 1'b0;
      #1;
      chk("R10", "lat_oe back", lat_oe, 1'b1);
      chk("R10", "cmd_oe back", cmd_oe, 1'b1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_wr = 1'b0; rdy = 1'b0; dma_en = 1'b0;
    start_addr = '0; start_wdata = '0; start_space = '0; ad_in = '0;
    repeat (3) tick();
    // R1: reset state
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "req_n", req_n, 1'b1);
    chk("R1", "cmd_n", cmd_n, 8'hFF);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1", "strobe", addr_strobe, 1'b0);
    chk("R1", "done", done, 1'b0);
    chk("R1", "ad_oe", ad_oe, 1'b0);
    chk("R1", "buf_oe", buf_oe, 1'b0);
    chk("R1", "rd_data", rd_data, 16'h0000);
    chk("R1", "lat_oe", lat_oe, 1'b1);
    chk("R1", "cmd_oe", cmd_oe, 1'b1);

    for (int k = 0; k < NV; k++) begin
      run_xfer(VECS[k], 1'b0, 1'b0);
    end

    // R11: stray start while busy
    run_xfer(VECS[2], 1'b1, 1'b0);
    tick();
    chk("R11", "no second cycle busy", busy, 1'b0);
    chk("R11", "no second strobe", addr_strobe, 1'b0);
    repeat (4) tick();
    chk("R11", "latched addr kept", lat_addr, VECS[2].addr);

    // R10: DMA takeover during a waited write
    run_xfer(VECS[5], 1'b0, 1'b1);

    report();
    $finish;
  end
endmodule